// File: doc/BRIEF.md
# Locked Configuration Port with GPIO Banks

This block is an indexed configuration space that a host reaches through two byte-wide I/O ports. A write to the first port (address bit 0 low) picks a register index. The second port (address bit 0 high) reads or writes the register at that index. The space stays locked until a two-byte key is written to the index port. Once it is unlocked, the host can read fixed identification registers and a logical-device selector. When the selector points at the GPIO function, the host can also reach a set of 8-bit pin banks.

Each bank has four registers: pin direction, output latch, pin input and drive mode. These registers drive per-pin output values and output enables toward the pads. External pin levels come back through a two-flop synchronizer. Some banks are narrower than eight pins, and a parameter mask marks which bits exist.

Top module: `cfg_space_gpio`

## Requirements
- R1: The space unlocks only after two consecutive index-port writes of 0x87 while locked. Any other index-port byte written while locked cancels a pending first key.
- R2: While locked, writes to the data port have no effect, and any read of either port returns 0xFF. The selected index is kept across a lock.
- R3: While unlocked, an index-port write of 0xAA locks the space again.
- R4: Register 0x20 returns the device-ID high byte and 0x21 returns the low byte (default 0x0909). Register 0x22 returns the revision byte (default 0x01). Registers 0x23 and 0x24 return the vendor ID 0x1934, high byte first. Unmapped registers read 0x00.
- R5: Register 0x07 is the logical-device selector. GPIO registers read 0x00 and ignore writes unless the selector holds 0x06.
- R6: Bank n (n = 0..NUM_BANKS-1) starts at index 0xF0 - 0x10*n. Offset 0 is direction, offset 1 is the output latch, offset 2 is pin input and offset 3 is drive mode. Direction, latch and mode read back the value written.
- R7: A pin with direction bit 1 and mode bit 1 (push-pull) has its output enable set and drives the latch bit.
- R8: A pin with direction bit 1 and mode bit 0 (open drain) has its enable set only when its latch bit is 0, and then drives 0. A pin with direction 0 is never enabled.
- R9: For input pins (direction 0), the pin-input register returns the external level after two clock edges and not after one. For output pins it returns the latch bit.
- R10: Bits outside a bank's implemented pin mask read as 0 in every bank register, and their pins are never enabled. The default bank widths are 7, 8, 8, 8, 8, 5, 8, 8 pins.
- R11: After reset the space is locked, the selector is 0, all direction, latch and mode bits are 0, and no pin is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ioAddr | input | 1 | 0 selects the index port, 1 selects the data port |
| ioWr | input | 1 | Write strobe, one cycle per byte |
| ioRd | input | 1 | Read strobe; read data is valid in the same cycle |
| ioWdata | input | 8 | Write data |
| ioRdata | output | 8 | Read data, 0 when no read is strobed |
| pinIn | input | NUM_BANKS*8 | External pin levels, bank n at bits 8n+7..8n |
| pinOut | output | NUM_BANKS*8 | Per-pin output value |
| pinOe | output | NUM_BANKS*8 | Per-pin output enable |

## Verification
The bench breaks a key pair with a different byte in between. A design that tracked the key loosely would unlock there and return real data where 0xFF belongs. It writes the data port while locked, then unlocks and reads the register back, which catches a design that lets locked writes through. It writes bank registers under a non-GPIO selector to expose missing gating. It also drives open-drain pins with mixed latch bits, where swapping the enable polarity would drive highs.

The bench times a pin change edge by edge, which catches a missing or extra synchronizer stage. It writes all-ones to the 7-pin and 5-pin banks, so a design that ignored the mask would read back or enable pins that do not exist.

// File: rtl/cfg_space_pkg.sv
package cfg_space_pkg;
  localparam logic [7:0] KEY_OPEN  = 8'h87;
  localparam logic [7:0] KEY_CLOSE = 8'hAA;
  localparam logic [7:0] REG_LDN   = 8'h07;
  localparam logic [7:0] GPIO_LDN  = 8'h06;
  localparam logic [7:0] REG_IDHI  = 8'h20;
  localparam logic [7:0] REG_IDLO  = 8'h21;
  localparam logic [7:0] REG_REV   = 8'h22;
  localparam logic [7:0] REG_VNHI  = 8'h23;
  localparam logic [7:0] REG_VNLO  = 8'h24;

  typedef enum logic [1:0] {
    F_DIR  = 2'd0,
    F_OUT  = 2'd1,
    F_PIN  = 2'd2,
    F_MODE = 2'd3
  } bankField_t;

  // strobes and state handed from control to datapath
  typedef struct packed {
    logic       unlocked;
    logic       dataWr;
    logic [7:0] idx;
    logic [7:0] wdata;
  } cfgCmd_t;
endpackage

// File: rtl/cfg_space_ctrl.sv
module cfg_space_ctrl
  import cfg_space_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ioAddr,
  input  logic       ioWr,
  input  logic [7:0] ioWdata,
  output cfgCmd_t    cmd
);
  logic       unlocked;
  logic       keySeen;
  logic [7:0] idx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      unlocked <= 1'b0;
      keySeen  <= 1'b0;
      idx      <= 8'h00;
    end else if (ioWr && !ioAddr) begin
      if (!unlocked) begin
        if (ioWdata == KEY_OPEN) begin
          unlocked <= keySeen;
          keySeen  <= !keySeen;
        end else begin
          keySeen <= 1'b0;
        end
      end else if (ioWdata == KEY_CLOSE) begin
        unlocked <= 1'b0;
      end else begin
        idx <= ioWdata;
      end
    end
  end

  assign cmd.unlocked = unlocked;
  assign cmd.dataWr   = ioWr && ioAddr && unlocked;
  assign cmd.idx      = idx;
  assign cmd.wdata    = ioWdata;
endmodule

// File: rtl/cfg_space_dp.sv
module cfg_space_dp
  import cfg_space_pkg::*;
#(
  parameter int                       NUM_BANKS = 8,
  parameter logic [NUM_BANKS*8-1:0]   PIN_MASK  = '1,
  parameter logic [15:0]              DEV_ID    = 16'h0909,
  parameter logic [15:0]              VENDOR_ID = 16'h1934,
  parameter logic [7:0]               DEV_REV   = 8'h01
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  cfgCmd_t                cmd,
  input  logic                   ioAddr,
  input  logic                   ioRd,
  input  logic [NUM_BANKS*8-1:0] pinIn,
  output logic [7:0]             ioRdata,
  output logic [NUM_BANKS*8-1:0] pinOut,
  output logic [NUM_BANKS*8-1:0] pinOe
);
  localparam int PW = NUM_BANKS * 8;

  logic [7:0]    ldn;
  logic [PW-1:0] dirR, outR, modeR, sync1, sync2;
  logic [3:0]    bankSel;
  logic          gpioHit;
  bankField_t    field;
  logic [7:0]    regData;

  assign bankSel = 4'hF - cmd.idx[7:4];
  assign field   = bankField_t'(cmd.idx[1:0]);
  assign gpioHit = (ldn == GPIO_LDN) && (cmd.idx[3:2] == 2'b00) &&
                   (int'(bankSel) < NUM_BANKS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ldn   <= 8'h00;
      dirR  <= '0;
      outR  <= '0;
      modeR <= '0;
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= pinIn;
      sync2 <= sync1;
      if (cmd.dataWr) begin
        if (cmd.idx == REG_LDN) ldn <= cmd.wdata;
        for (int b = 0; b < NUM_BANKS; b++) begin
          if (gpioHit && bankSel == 4'(b)) begin
            case (field)
              F_DIR:   dirR[b*8 +: 8]  <= cmd.wdata & PIN_MASK[b*8 +: 8];
              F_OUT:   outR[b*8 +: 8]  <= cmd.wdata & PIN_MASK[b*8 +: 8];
              F_MODE:  modeR[b*8 +: 8] <= cmd.wdata & PIN_MASK[b*8 +: 8];
              default: ;
            endcase
          end
        end
      end
    end
  end

  always_comb begin
    regData = 8'h00;
    case (cmd.idx)
      REG_LDN:  regData = ldn;
      REG_IDHI: regData = DEV_ID[15:8];
      REG_IDLO: regData = DEV_ID[7:0];
      REG_REV:  regData = DEV_REV;
      REG_VNHI: regData = VENDOR_ID[15:8];
      REG_VNLO: regData = VENDOR_ID[7:0];
      default: begin
        for (int b = 0; b < NUM_BANKS; b++) begin
          if (gpioHit && bankSel == 4'(b)) begin
            case (field)
              F_DIR:  regData = dirR[b*8 +: 8];
              F_OUT:  regData = outR[b*8 +: 8];
              F_PIN:  regData = ((dirR[b*8 +: 8] & outR[b*8 +: 8]) |
                                 (~dirR[b*8 +: 8] & sync2[b*8 +: 8])) &
                                PIN_MASK[b*8 +: 8];
              F_MODE: regData = modeR[b*8 +: 8];
              default: ;
            endcase
          end
        end
      end
    endcase
  end

  always_comb begin
    if (!ioRd)             ioRdata = 8'h00;
    else if (!cmd.unlocked) ioRdata = 8'hFF;
    else if (ioAddr)       ioRdata = regData;
    else                   ioRdata = cmd.idx;
  end

  for (genvar p = 0; p < PW; p++) begin : g_pad
    assign pinOe[p]  = dirR[p] && (modeR[p] || !outR[p]);
    assign pinOut[p] = outR[p];
  end
endmodule

// File: rtl/cfg_space_gpio.sv
module cfg_space_gpio
  import cfg_space_pkg::*;
#(
  parameter int                     NUM_BANKS = 8,
  parameter logic [NUM_BANKS*8-1:0] PIN_MASK  = 64'hFF_FF_1F_FF_FF_FF_FF_7F,
  parameter logic [15:0]            DEV_ID    = 16'h0909,
  parameter logic [15:0]            VENDOR_ID = 16'h1934,
  parameter logic [7:0]             DEV_REV   = 8'h01
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   ioAddr,
  input  logic                   ioWr,
  input  logic                   ioRd,
  input  logic [7:0]             ioWdata,
  output logic [7:0]             ioRdata,
  input  logic [NUM_BANKS*8-1:0] pinIn,
  output logic [NUM_BANKS*8-1:0] pinOut,
  output logic [NUM_BANKS*8-1:0] pinOe
);
  cfgCmd_t cmd;
  logic    unlocked;

  assign unlocked = cmd.unlocked;

  cfg_space_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWr(ioWr),
    .ioWdata(ioWdata), .cmd(cmd)
  );

  cfg_space_dp #(
    .NUM_BANKS(NUM_BANKS), .PIN_MASK(PIN_MASK), .DEV_ID(DEV_ID),
    .VENDOR_ID(VENDOR_ID), .DEV_REV(DEV_REV)
  ) dp_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .ioAddr(ioAddr), .ioRd(ioRd),
    .pinIn(pinIn), .ioRdata(ioRdata), .pinOut(pinOut), .pinOe(pinOe)
  );
endmodule

// File: rtl/cfg_space_gpio_chk.sv
module cfg_space_gpio_chk #(
  parameter int               PIN_W    = 64,
  parameter logic [PIN_W-1:0] PIN_MASK = '1
) (
  input logic             clk,
  input logic             rstN,
  input logic             ioAddr,
  input logic             ioWr,
  input logic             ioRd,
  input logic [7:0]       ioWdata,
  input logic [7:0]       ioRdata,
  input logic [PIN_W-1:0] pinOe,
  input logic             unlocked
);
  // R1
  unlock_key_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(unlocked) |-> $past(ioWr && !ioAddr && ioWdata == 8'h87));

  // R2
  locked_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!unlocked && ioRd) |-> ioRdata == 8'hFF);

  // R2
  locked_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!unlocked && ioWr && ioAddr) |=> $stable(pinOe));

  // R3
  lock_key_chk: assert property (@(posedge clk) disable iff (!rstN)
    (unlocked && ioWr && !ioAddr && ioWdata == 8'hAA) |=> !unlocked);

  // R10
  unimpl_pin_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pinOe & ~PIN_MASK) == '0);
endmodule

bind cfg_space_gpio cfg_space_gpio_chk #(
  .PIN_W(NUM_BANKS*8), .PIN_MASK(PIN_MASK)
) chk_i (
  .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWr(ioWr), .ioRd(ioRd),
  .ioWdata(ioWdata), .ioRdata(ioRdata), .pinOe(pinOe), .unlocked(unlocked)
);

// File: tb/cfg_space_gpio_tb_top.sv
module cfg_space_gpio_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 64;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          ioAddr = 1'b0, ioWr = 1'b0, ioRd = 1'b0;
  logic [7:0]    ioWdata = 8'h00;
  logic [7:0]    ioRdata;
  logic [PW-1:0] pinIn = '0;
  logic [PW-1:0] pinOut, pinOe;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_space_gpio dut_i (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWr(ioWr), .ioRd(ioRd),
    .ioWdata(ioWdata), .ioRdata(ioRdata), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    ioAddr = a; ioWr = 1'b1; ioWdata = d;
    @(negedge clk);
    ioWr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk);
    ioAddr = a; ioRd = 1'b1;
    #1 d = ioRdata;
    ioRd = 1'b0;
  endtask

  task automatic setReg(input logic [7:0] i, input logic [7:0] v);
    wr(1'b0, i); wr(1'b1, v);
  endtask

  task automatic getReg(input logic [7:0] i, output logic [7:0] v);
    wr(1'b0, i); rd(1'b1, v);
  endtask

  task automatic unlock();
    wr(1'b0, 8'h87); wr(1'b0, 8'h87);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(1'b1, v);  check("R11 locked after reset", v, 8'hFF);
    check("R11 no pin enabled", pinOe, '0);
    unlock();
    getReg(8'h07, v); check("R11 selector zero", v, 8'h00);
    setReg(8'h07, 8'h06);
    getReg(8'hF0, v); check("R11 dir zero", v, 8'h00);
    getReg(8'hE1, v); check("R11 latch zero", v, 8'h00);
    getReg(8'hD3, v); check("R11 mode zero", v, 8'h00);
    wr(1'b0, 8'hAA);
  endtask

  task automatic t_unlock();
    logic [7:0] v;
    wr(1'b0, 8'h20);
    wr(1'b0, 8'h87); wr(1'b0, 8'h55); wr(1'b0, 8'h87);
    rd(1'b1, v); check("R1 broken key stays locked", v, 8'hFF);
    wr(1'b0, 8'h87);
    wr(1'b0, 8'h20);
    rd(1'b1, v); check("R1 double key unlocks", v, 8'h09);
  endtask

  task automatic t_ids();
    logic [7:0] v;
    getReg(8'h20, v); check("R4 id hi", v, 8'h09);
    getReg(8'h21, v); check("R4 id lo", v, 8'h09);
    getReg(8'h22, v); check("R4 rev", v, 8'h01);
    getReg(8'h23, v); check("R4 vendor hi", v, 8'h19);
    getReg(8'h24, v); check("R4 vendor lo", v, 8'h34);
    getReg(8'h30, v); check("R4 unmapped", v, 8'h00);
  endtask

  task automatic t_ldn_gate();
    logic [7:0] v;
    setReg(8'h07, 8'h05);
    setReg(8'hE3, 8'hFF); setReg(8'hE0, 8'hFF);
    getReg(8'hE0, v); check("R5 gpio hidden read", v, 8'h00);
    check("R5 hidden write no drive", pinOe, '0);
    setReg(8'h07, 8'h06);
    getReg(8'hE0, v); check("R5 hidden write ignored", v, 8'h00);
  endtask

  task automatic t_pushpull();
    logic [7:0] v;
    setReg(8'hE3, 8'hFF); setReg(8'hE1, 8'hA5); setReg(8'hE0, 8'hFF);
    check("R7 push-pull enable", pinOe[15:8], 8'hFF);
    check("R7 push-pull value", pinOut[15:8], 8'hA5);
    getReg(8'hE0, v); check("R6 dir readback", v, 8'hFF);
    getReg(8'hE1, v); check("R6 latch readback", v, 8'hA5);
    getReg(8'hE3, v); check("R6 mode readback", v, 8'hFF);
  endtask

  task automatic t_opendrain();
    setReg(8'hD1, 8'h0F); setReg(8'hD0, 8'hFF);
    check("R8 open-drain enable", pinOe[23:16], 8'hF0);
    check("R8 open-drain drives low", pinOut[23:16] & pinOe[23:16], 8'h00);
    setReg(8'hD0, 8'h00);
    check("R8 input never enabled", pinOe[23:16], 8'h00);
  endtask

  task automatic t_pinin();
    logic [7:0] v;
    wr(1'b0, 8'hC2);
    @(negedge clk); pinIn[31:24] = 8'h3C;
    rd(1'b1, v); check("R9 one edge not visible", v, 8'h00);
    rd(1'b1, v); check("R9 two edges visible", v, 8'h3C);
    setReg(8'hC1, 8'h05); setReg(8'hC0, 8'h0F);
    getReg(8'hC2, v); check("R9 output pins read latch", v, 8'h35);
  endtask

  task automatic t_mask();
    logic [7:0] v;
    setReg(8'hF3, 8'hFF); setReg(8'hF0, 8'hFF);
    getReg(8'hF0, v); check("R10 bank0 dir masked", v, 8'h7F);
    check("R10 bank0 pin7 never enabled", pinOe[7:0], 8'h7F);
    setReg(8'hA1, 8'hFF);
    getReg(8'hA1, v); check("R10 bank5 latch masked", v, 8'h1F);
    pinIn[47:40] = 8'hFF;
    repeat (3) @(negedge clk);
    getReg(8'hA2, v); check("R10 bank5 pin input masked", v, 8'h1F);
  endtask

  task automatic t_lock();
    logic [7:0] v;
    wr(1'b0, 8'hA1);
    wr(1'b0, 8'hAA);
    rd(1'b1, v); check("R3 locked after close key", v, 8'hFF);
    rd(1'b0, v); check("R2 index port reads FF", v, 8'hFF);
    wr(1'b1, 8'h00);
    unlock();
    rd(1'b1, v); check("R2 locked write ignored", v, 8'h1F);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_unlock();
    t_ids();
    t_ldn_gate();
    t_pushpull();
    t_opendrain();
    t_pinin();
    t_mask();
    t_lock();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule